// File: doc/BRIEF.md
# Slow-Sampled Pin Interrupt Bank

This block watches eight input pins and raises a single interrupt line when any enabled pin shows its chosen trigger condition. Detection runs entirely in a low-rate sample clock domain (nominally 32 kHz). Pins are resynchronised there, compared against their previous sample, and the results are latched into per-channel status bits. Software configures and services the bank through a small register port in the bus clock domain. Each channel has its own mode, polarity and any-edge control bits, and together these select one of five trigger types: rising edge, falling edge, either edge, high level or low level.

Status bits are sticky. They stay set until software writes a one to the clear register. A clear request reaches the sample domain as a per-channel toggle. Status and pin levels come back to the bus domain through two-flop synchronisers. The interrupt output is the OR of all status bits that are also enabled.

Top module: `lr_irq_bank`

## Requirements
- R1: After reset every register reads 0 and `irq` is low (pins held low).
- R2: Registers sit at these byte addresses: enable 0x00, raw status 0x04, masked status 0x08, clear 0x0C, level-mode 0x10, any-edge 0x14, polarity 0x18, pin data 0x1C. Bit i of each register belongs to channel i. Enable, level-mode, any-edge and polarity read back what was written. The clear register reads as 0.
- R3: Pin data bit i reads the current level of pin i, after synchronisation delay.
- R4: With level-mode=0 and any-edge=0, polarity=1 latches raw status on a rising pin edge, and polarity=0 latches it on a falling edge.
- R5: With level-mode=0 and any-edge=1, both edges latch raw status, whatever the polarity bit holds.
- R6: With level-mode=1, polarity=1 latches raw status while the pin is high, and polarity=0 latches it while the pin is low.
- R7: A raw status bit stays set until a 1 is written to its bit in the clear register. Bits written as 0 leave their channels unchanged.
- R8: In level mode, a cleared bit sets again if the pin is still at its active level.
- R9: Masked status equals raw status AND enable. The enable setting does not change raw status.
- R10: `irq` is high exactly when masked status is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock for the register port |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| smp_clk | input | 1 | Low-rate sample clock for detection |
| pins | input | 8 | Asynchronous interrupt input pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on address) |
| irq | output | 1 | Interrupt output |

## Verification
The assertions check several properties on every cycle. In the sample domain, a status bit never drops unless a clear reached it, and a clear always empties its channel in the following cycle. In the bus domain, a write to the clear register flips exactly the written toggle bits, and `irq` never rises while enable is zero or raw status is empty. The bench scenarios are needed for the rest: whether each of the five trigger types latches on the right pin transitions, whether polarity is ignored in any-edge mode, whether level status re-arms after a clear, and whether the values crossing the domains come back correct. The bench sweeps all trigger types across all eight channels with varied pin patterns and enable masks.

// File: rtl/lrib_pkg.sv
package lrib_pkg;

    localparam int AW = 5;

    typedef enum logic [AW-1:0] {
        A_EN  = 5'h00,
        A_RAW = 5'h04,
        A_MSK = 5'h08,
        A_CLR = 5'h0C,
        A_LVL = 5'h10,
        A_ANY = 5'h14,
        A_POL = 5'h18,
        A_PIN = 5'h1C
    } reg_addr_e;

    // Trigger decision for one channel from its three control bits.
    function automatic logic trig_hit(logic lvl, logic any, logic pol,
                                      logic cur, logic prev);
        if (lvl)
            return pol ? cur : ~cur;
        else if (any)
            return cur ^ prev;
        else
            return pol ? (cur & ~prev) : (prev & ~cur);
    endfunction

endpackage

// File: rtl/lrib_sync.sv
module lrib_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/lrib_detect.sv
module lrib_detect #(
    parameter int N = 8
) (
    input  logic         smp_clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] any,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] clr_tgl,
    output logic [N-1:0] status,
    output logic [N-1:0] level,
    output logic [N-1:0] clr
);
    localparam int CW = 3 * N;

    logic [N-1:0]  pin_s;
    logic [N-1:0]  tgl_s;
    logic [CW-1:0] cfg_s;
    logic [N-1:0]  hit;

    lrib_sync #(.W(N)) u_pin_sync (
        .clk(smp_clk), .rst_n(rst_n), .din(pins), .dout(pin_s));

    lrib_sync #(.W(CW)) u_cfg_sync (
        .clk(smp_clk), .rst_n(rst_n), .din({lvl, any, pol}), .dout(cfg_s));

    lrib_sync #(.W(N)) u_tgl_sync (
        .clk(smp_clk), .rst_n(rst_n), .din(clr_tgl), .dout(tgl_s));

    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] tgl_prev;
        logic [N-1:0] status;
    } det_t;

    det_t st_d, st_q;

    generate
        for (genvar i = 0; i < N; i++) begin : g_ch
            assign hit[i] = lrib_pkg::trig_hit(cfg_s[2*N+i], cfg_s[N+i], cfg_s[i],
                                               pin_s[i], st_q.prev[i]);
        end
    endgenerate

    assign clr = tgl_s ^ st_q.tgl_prev;

    always_comb begin
        st_d          = st_q;
        st_d.prev     = pin_s;
        st_d.tgl_prev = tgl_s;
        // A clear arriving in the same sample wins; level re-arms next sample.
        st_d.status   = (st_q.status | hit) & ~clr;
    end

    always_ff @(posedge smp_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.status;
    assign level  = pin_s;
endmodule

// File: rtl/lrib_regs.sv
module lrib_regs #(
    parameter int N = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [lrib_pkg::AW-1:0] addr,
    input  logic [N-1:0]           wdata,
    input  logic [N-1:0]           raw,
    input  logic [N-1:0]           level,
    output logic [N-1:0]           rdata,
    output logic [N-1:0]           en,
    output logic [N-1:0]           lvl,
    output logic [N-1:0]           any,
    output logic [N-1:0]           pol,
    output logic [N-1:0]           clr_tgl,
    output logic                   irq
);
    import lrib_pkg::*;

    typedef struct packed {
        logic [N-1:0] en;
        logic [N-1:0] lvl;
        logic [N-1:0] any;
        logic [N-1:0] pol;
        logic [N-1:0] tgl;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (reg_addr_e'(addr))
                A_EN:    r_d.en  = wdata;
                A_LVL:   r_d.lvl = wdata;
                A_ANY:   r_d.any = wdata;
                A_POL:   r_d.pol = wdata;
                A_CLR:   r_d.tgl = r_q.tgl ^ wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (reg_addr_e'(addr))
            A_EN:    rdata = r_q.en;
            A_RAW:   rdata = raw;
            A_MSK:   rdata = raw & r_q.en;
            A_LVL:   rdata = r_q.lvl;
            A_ANY:   rdata = r_q.any;
            A_POL:   rdata = r_q.pol;
            A_PIN:   rdata = level;
            default: rdata = '0;
        endcase
    end

    assign en      = r_q.en;
    assign lvl     = r_q.lvl;
    assign any     = r_q.any;
    assign pol     = r_q.pol;
    assign clr_tgl = r_q.tgl;
    assign irq     = |(raw & r_q.en);
endmodule

// File: rtl/lr_irq_bank.sv
module lr_irq_bank #(
    parameter int N_CH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_clk,
    input  logic [N_CH-1:0]         pins,
    input  logic                    reg_we,
    input  logic [lrib_pkg::AW-1:0] reg_addr,
    input  logic [N_CH-1:0]         reg_wdata,
    output logic [N_CH-1:0]         reg_rdata,
    output logic                    irq
);
    localparam int BW = 2 * N_CH;

    logic [N_CH-1:0] en_w, lvl_w, any_w, pol_w, tgl_w;
    logic [N_CH-1:0] smp_status, smp_level, smp_clr;
    logic [N_CH-1:0] raw_w, level_w;

    lrib_regs #(.N(N_CH)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .raw(raw_w), .level(level_w), .rdata(reg_rdata),
        .en(en_w), .lvl(lvl_w), .any(any_w), .pol(pol_w),
        .clr_tgl(tgl_w), .irq(irq));

    lrib_detect #(.N(N_CH)) u_det (
        .smp_clk(smp_clk), .rst_n(rst_n), .pins(pins),
        .lvl(lvl_w), .any(any_w), .pol(pol_w), .clr_tgl(tgl_w),
        .status(smp_status), .level(smp_level), .clr(smp_clr));

    lrib_sync #(.W(BW)) u_back_sync (
        .clk(clk), .rst_n(rst_n), .din({smp_status, smp_level}),
        .dout({raw_w, level_w}));
endmodule

// File: rtl/lrib_chk.sv
module lrib_chk #(
    parameter int N = 8
) (
    input logic                    clk,
    input logic                    smp_clk,
    input logic                    rst_n,
    input logic                    reg_we,
    input logic [lrib_pkg::AW-1:0] reg_addr,
    input logic [N-1:0]            reg_wdata,
    input logic [N-1:0]            en,
    input logic [N-1:0]            raw,
    input logic                    irq,
    input logic [N-1:0]            clr_tgl,
    input logic [N-1:0]            smp_status,
    input logic [N-1:0]            smp_clr
);
    import lrib_pkg::*;

    // R10
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq);

    // R10
    irq_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw != '0));

    // R7
    clr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_CLR) |=> (clr_tgl == ($past(clr_tgl) ^ $past(reg_wdata))));

    // R7
    clear_empties_chk: assert property (@(posedge smp_clk) disable iff (!rst_n)
        (smp_clr != '0) |=> ((smp_status & $past(smp_clr)) == '0));

    // R7
    status_sticky_chk: assert property (@(posedge smp_clk) disable iff (!rst_n)
        (($past(smp_status) & ~$past(smp_clr) & ~smp_status) == '0));
endmodule

bind lr_irq_bank lrib_chk #(.N(N_CH)) u_chk (
    .clk(clk), .smp_clk(smp_clk), .rst_n(rst_n), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .en(en_w), .raw(raw_w),
    .irq(irq), .clr_tgl(tgl_w), .smp_status(smp_status), .smp_clr(smp_clr));

// File: tb/lr_irq_bank_tb.sv
module lr_irq_bank_tb;
    logic       clk = 0, smp_clk = 0, rst_n = 0;
    logic [7:0] pins = '0;
    logic       reg_we = 0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4   clk = ~clk;       // 125 MHz bus clock
    always #100 smp_clk = ~smp_clk; // sample clock, scaled up to keep the run short

    lr_irq_bank u_dut (.clk(clk), .rst_n(rst_n), .smp_clk(smp_clk), .pins(pins),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq));

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [7:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(logic [4:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic settle();
        repeat (320) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_hit(bit l, bit a, bit p, logic [7:0] c, logic [7:0] pr);
        if (l) return p ? c : ~c;
        if (a) return c ^ pr;
        return p ? (c & ~pr) : (pr & ~c);
    endfunction

    task automatic check_all(string req, logic [7:0] model, logic [7:0] en, logic [7:0] lv);
        logic [7:0] v;
        rd(5'h04, v); chk(req, "raw", v, model);
        rd(5'h08, v); chk("R9", "masked", v, model & en);
        #1; chk("R10", "irq", {7'd0, irq}, {7'd0, |(model & en)});
        rd(5'h1C, v); chk("R3", "pin data", v, lv);
    endtask

    task automatic run_cfg(string req, bit l, bit a, bit p, logic [7:0] en);
        logic [7:0] model, prevp, c;
        logic [7:0] pats [5] = '{8'hA5, 8'h5A, 8'hFF, 8'h00, 8'h3C};
        pins = '0;
        wr(5'h10, {8{l}}); wr(5'h14, {8{a}}); wr(5'h18, {8{p}}); wr(5'h00, en);
        settle();
        wr(5'h0C, 8'hFF);
        settle();
        prevp = '0;
        model = l ? (p ? 8'h00 : 8'hFF) : 8'h00;
        check_all(req, model, en, prevp);
        for (int k = 0; k < 5; k++) begin
            pins = pats[k];
            settle();
            model = model | exp_hit(l, a, p, pats[k], prevp);
            prevp = pats[k];
            check_all(req, model, en, prevp);
            c = k[0] ? 8'hF0 : 8'h0F;
            wr(5'h0C, c);
            settle();
            model = (model & ~c) | (l ? (p ? prevp : ~prevp) : 8'h00);
            check_all(l ? "R8" : "R7", model, en, prevp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), v); chk("R1", "reset reg", v, 8'h00);
        end
        #1; chk("R1", "reset irq", {7'd0, irq}, 8'h00);
        // R2 readback and clear register reading zero
        wr(5'h10, 8'h96); rd(5'h10, v); chk("R2", "level-mode rb", v, 8'h96);
        wr(5'h14, 8'h3C); rd(5'h14, v); chk("R2", "any-edge rb", v, 8'h3C);
        wr(5'h18, 8'hC3); rd(5'h18, v); chk("R2", "polarity rb", v, 8'hC3);
        wr(5'h00, 8'h69); rd(5'h00, v); chk("R2", "enable rb", v, 8'h69);
        wr(5'h0C, 8'h00); rd(5'h0C, v); chk("R2", "clear reads 0", v, 8'h00);
        // trigger type sweep over all channels
        run_cfg("R4", 0, 0, 1, 8'hFF);
        run_cfg("R4", 0, 0, 0, 8'h3C);
        run_cfg("R5", 0, 1, 0, 8'h81);
        run_cfg("R5", 0, 1, 1, 8'h00);
        run_cfg("R6", 1, 0, 1, 8'hA5);
        run_cfg("R6", 1, 0, 0, 8'h5A);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule